// File: doc/BRIEF.md
# Beamformer Serial Configuration Port and Access Controller

This block is the configuration front end of a multi-channel transmit beamformer. A host streams a 50-bit frame into one serial data pin, two bits per clock: one bit is sampled on the falling edge and the next on the rising edge. A frame names a target register, says whether the access is a write or a read, and carries a 25-bit channel delay word and a 19-bit control word. When the host drops the latch-enable line, and only if the transmit start line is also low, the frame is handed to a small state machine. The state machine moves to a channel access state or to a control access state for one cycle, performs the write or loads the read-back shifter, and returns to idle.

The stored channel delay words go out to the per-channel pulse timers. The control word is decoded into fields for the rest of the transmitter: pulse pattern length, pattern frequency divider, pulse-echo or doppler mode, two source-select bits for addresses and delay data, and a per-channel enable mask built from the active-channel count. Reads come back on a serial output pin, most significant bit first.

States: `S_IDLE` (waits for a committed frame), `S_CHAN` (one-cycle access to a channel delay register), `S_CTRL` (one-cycle access to the control register). Transitions: `S_IDLE` to `S_CHAN` on a committed frame whose address is 1 to 16; `S_IDLE` to `S_CTRL` on a committed frame whose address is 17; `S_IDLE` stays put on any other address or without a commit; `S_CHAN` and `S_CTRL` always return to `S_IDLE` after one cycle.

Top module: `bf_serial_cfg`

## Requirements
- R1: After active-high reset every channel delay register and the control register read 0, the serial output is 0, and the state machine is in `S_IDLE`.
- R2: In each clock cycle with latch enable high, the bit present at the falling edge is taken first and the bit present at the following rising edge second; the 50 frame bits arrive in the order address[4:0] (MSB first), write bit (1 = write, 0 = read), delay[24:0] (MSB first), control[18:0] (MSB first).
- R3: A frame is committed only when latch enable returns low after exactly 25 bit pairs; a shorter or longer frame is discarded with no register change.
- R4: A committed frame with address 1 to 16 causes one `S_CHAN` cycle, address 17 one `S_CTRL` cycle; each access state returns to `S_IDLE` on the next cycle, so back-to-back frames are all served.
- R5: A write to address a (1 to 16) loads the frame's delay field into channel a-1's delay register (bits [25*(a-1)+24 : 25*(a-1)] of the delay bus); other channels and the control register are unchanged.
- R6: A write to address 17 loads the frame's control field into the control register with bits [14:12] cleared; the frame's delay field has no effect on any channel.
- R7: A read (write bit 0) to a valid address changes no register and shifts the addressed register out on the serial output MSB first, one bit per rising edge, the first bit valid in the third cycle after latch enable falls; a control read gives 19 bits with bits [14:12] as 0.
- R8: Frames with address 0 or 18 to 31 leave every register unchanged and start no read-back (the serial output stays 0 once drained).
- R9: With control bits [17:15] = n, channels 0 to 2n+1 are enabled and all higher channels are disabled (2, 4, ... 16 active channels).
- R10: The decoded outputs follow the control register: pattern length = bits [2:0], frequency divider = bits [9:3], doppler mode = bit 10 (1 = doppler, 0 = pulse-echo), delay data from lookup memory = bit 11, addresses from lookup memory = bit 18.
- R11: A frame whose latch enable falls while transmit start is high is discarded with no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; serial data sampled on both edges |
| rst | input | 1 | Active-high asynchronous reset |
| cfg_sdi | input | 1 | Serial frame data, two bits per clock |
| cfg_sle | input | 1 | Frame window: high while shifting, low to commit |
| tx_start | input | 1 | Transmit start; high blocks commit |
| cfg_sdo | output | 1 | Serial read-back data, MSB first |
| ch_delay | output | 400 | Channel delay registers, channel i at bits [25i+24:25i] |
| ctl_word | output | 19 | Control register contents (reserved bits read 0) |
| ch_enable | output | 16 | Per-channel enable from the active-channel count |
| pulse_len | output | 3 | Pulse pattern length field |
| freq_div | output | 7 | Pattern frequency divider field |
| doppler_mode | output | 1 | 1 = doppler, 0 = pulse-echo |
| lut_data_sel | output | 1 | Delay data taken from lookup memory |
| lut_addr_sel | output | 1 | Addresses taken from lookup memory |

## Verification
The hardest situations to reach are the frames that must be thrown away: a frame one pair short or one pair long, a frame ended while transmit start is high, and addresses 0 or 18 to 31, since each leaves no trace except the absence of a change. The bench drives every one of these through the serial pins with distinctive payloads right after all registers hold known, distinct values, then compares the full delay bus and control word against its own model, and for read frames watches the serial output for 25 cycles. Read-back timing is pinned by sampling the serial output in the exact cycle the first bit must appear, after a sweep that writes and reads all 16 channels and all eight active-channel counts.

// File: rtl/bfcfg_pkg.sv
package bfcfg_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CHAN = 2'd1,
        S_CTRL = 2'd2
    } cfg_state_t;

    // Control word field positions (decoded by the channel logic)
    localparam int PLEN_LSB = 0;
    localparam int PLEN_W   = 3;
    localparam int FDIV_LSB = 3;
    localparam int FDIV_W   = 7;
    localparam int DOP_BIT  = 10;
    localparam int LUTD_BIT = 11;
    localparam int RSV_LSB  = 12;
    localparam int RSV_W    = 3;
    localparam int ACT_LSB  = 15;
    localparam int ACT_W    = 3;
    localparam int LUTA_BIT = 18;
endpackage

// File: rtl/bfcfg_ddr_rx.sv
module bfcfg_ddr_rx #(
    parameter int FRAME_W = 50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sdi,
    input  logic               sle,
    input  logic               tx_start,
    output logic [FRAME_W-1:0] frame,
    output logic               commit
);
    localparam int PAIRS = FRAME_W / 2;
    localparam int CNT_W = $clog2(PAIRS + 2);

    logic             neg_q;
    logic             pos_q;
    logic             hold_neg;
    logic             vld;
    logic             last_vld;
    logic [CNT_W-1:0] pair_cnt;
    logic [FRAME_W-1:0] shreg;

    // falling-edge sampler: first bit of each pair
    always_ff @(negedge clk or posedge rst) begin
        if (rst) neg_q <= 1'b0;
        else     neg_q <= sdi;
    end

    // rising-edge sampler: second bit of each pair, plus window tracking
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pos_q    <= 1'b0;
            hold_neg <= 1'b0;
            vld      <= 1'b0;
            last_vld <= 1'b0;
        end else begin
            pos_q    <= sdi;
            hold_neg <= neg_q;
            vld      <= sle;
            last_vld <= vld;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            shreg    <= '0;
            pair_cnt <= '0;
        end else if (vld) begin
            shreg <= {shreg[FRAME_W-3:0], hold_neg, pos_q};
            if (pair_cnt != CNT_W'(PAIRS + 1))
                pair_cnt <= pair_cnt + CNT_W'(1);
        end else begin
            pair_cnt <= '0;
        end
    end

    assign frame  = shreg;
    assign commit = last_vld & ~vld & (pair_cnt == CNT_W'(PAIRS)) & ~tx_start;

    // R3: a commit is a single-cycle event per frame window
    p_single_commit_r3: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
    // R3: the pair counter saturates one past a full frame
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        pair_cnt <= CNT_W'(PAIRS + 1));
    // R11: transmit start high never lets a frame through
    p_txstart_block_r11: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> !commit);
endmodule

// File: rtl/bfcfg_fsm.sv
module bfcfg_fsm
    import bfcfg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 5,
    parameter int DLY_W  = 25,
    parameter int CTL_W  = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    commit,
    input  logic [ADDR_W-1:0]       f_addr,
    input  logic                    f_wr,
    input  logic [DLY_W-1:0]        f_dly,
    input  logic [CTL_W-1:0]        f_ctl,
    output logic [NUM_CH*DLY_W-1:0] dly_flat,
    output logic [CTL_W-1:0]        ctl_q,
    output logic                    sdo
);
    localparam int IDX_W = $clog2(NUM_CH);
    localparam int PAD_W = DLY_W - CTL_W;
    localparam logic [CTL_W-1:0] RSV_MASK = CTL_W'(((1 << RSV_W) - 1) << RSV_LSB);

    cfg_state_t       state, state_nx;
    logic             req_wr;
    logic [IDX_W-1:0] req_idx;
    logic [DLY_W-1:0] req_dly;
    logic [CTL_W-1:0] req_ctl;
    logic [DLY_W-1:0] rb_q;
    logic [DLY_W-1:0] dly_mem [NUM_CH];
    logic             addr_is_chan;
    logic             addr_is_ctrl;

    assign addr_is_chan = (f_addr >= ADDR_W'(1)) && (f_addr <= ADDR_W'(NUM_CH));
    assign addr_is_ctrl = (f_addr == ADDR_W'(NUM_CH + 1));

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (commit && addr_is_chan)      state_nx = S_CHAN;
                else if (commit && addr_is_ctrl) state_nx = S_CTRL;
            end
            S_CHAN:  state_nx = S_IDLE;
            S_CTRL:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // request latch, register file and read-back shifter
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            req_wr  <= 1'b0;
            req_idx <= '0;
            req_dly <= '0;
            req_ctl <= '0;
            ctl_q   <= '0;
            rb_q    <= '0;
            for (int i = 0; i < NUM_CH; i++) dly_mem[i] <= '0;
        end else begin
            if (state == S_IDLE && commit) begin
                req_wr  <= f_wr;
                req_idx <= IDX_W'(f_addr - ADDR_W'(1));
                req_dly <= f_dly;
                req_ctl <= f_ctl;
            end
            unique case (state)
                S_CHAN: begin
                    if (req_wr) begin
                        dly_mem[req_idx] <= req_dly;
                        rb_q <= {rb_q[DLY_W-2:0], 1'b0};
                    end else begin
                        rb_q <= dly_mem[req_idx];
                    end
                end
                S_CTRL: begin
                    if (req_wr) begin
                        ctl_q <= req_ctl & ~RSV_MASK;
                        rb_q  <= {rb_q[DLY_W-2:0], 1'b0};
                    end else begin
                        rb_q <= {ctl_q, {PAD_W{1'b0}}};
                    end
                end
                default: rb_q <= {rb_q[DLY_W-2:0], 1'b0};
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
            assign dly_flat[g*DLY_W +: DLY_W] = dly_mem[g];
        end
    endgenerate

    assign sdo = rb_q[DLY_W-1];

    // R4: an access state lasts exactly one cycle
    p_one_cycle_access_r4: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> (state == S_IDLE));
    // R8: an out-of-range address keeps the machine idle
    p_bad_addr_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && commit && !addr_is_chan && !addr_is_ctrl) |=> (state == S_IDLE));
    // R5: channel registers move only after a channel access cycle
    p_delay_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state != S_CHAN) |=> $stable(dly_flat));
    // R6: control register moves only after a control access cycle
    p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state != S_CTRL) |=> $stable(ctl_q));
    // R7: a read never writes the register file
    p_read_no_write_r7: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && !req_wr) |=> ($stable(dly_flat) && $stable(ctl_q)));
endmodule

// File: rtl/bfcfg_ctl_decode.sv
module bfcfg_ctl_decode
    import bfcfg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CTL_W  = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTL_W-1:0]  ctl,
    output logic [NUM_CH-1:0] ch_en,
    output logic [PLEN_W-1:0] plen,
    output logic [FDIV_W-1:0] fdiv,
    output logic              dop,
    output logic              lut_d,
    output logic              lut_a
);
    localparam int CNT_W = ACT_W + 2;

    logic [ACT_W-1:0] act_code;
    logic [CNT_W-1:0] act_cnt;
    logic             unused_rsv;

    assign act_code   = ctl[ACT_LSB +: ACT_W];
    assign act_cnt    = {1'b0, act_code, 1'b0} + CNT_W'(2);
    assign unused_rsv = ^ctl[RSV_LSB +: RSV_W];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_en
            assign ch_en[g] = (CNT_W'(g) < act_cnt);
        end
    endgenerate

    assign plen  = ctl[PLEN_LSB +: PLEN_W];
    assign fdiv  = ctl[FDIV_LSB +: FDIV_W];
    assign dop   = ctl[DOP_BIT];
    assign lut_d = ctl[LUTD_BIT];
    assign lut_a = ctl[LUTA_BIT];

    // R9: the enable mask holds exactly the decoded count of channels
    p_en_count_r9: assert property (@(posedge clk) disable iff (rst)
        $countones(ch_en) == 32'(act_cnt));
    // R9: enables form a contiguous run from channel 0
    p_en_contig_r9: assert property (@(posedge clk) disable iff (rst)
        ch_en[0] && ((ch_en & (ch_en + NUM_CH'(1))) == '0));
endmodule

// File: rtl/bf_serial_cfg.sv
module bf_serial_cfg
    import bfcfg_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 5,
    parameter int DLY_W  = 25,
    parameter int CTL_W  = 19
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_sdi,
    input  logic                    cfg_sle,
    input  logic                    tx_start,
    output logic                    cfg_sdo,
    output logic [NUM_CH*DLY_W-1:0] ch_delay,
    output logic [CTL_W-1:0]        ctl_word,
    output logic [NUM_CH-1:0]       ch_enable,
    output logic [PLEN_W-1:0]       pulse_len,
    output logic [FDIV_W-1:0]       freq_div,
    output logic                    doppler_mode,
    output logic                    lut_data_sel,
    output logic                    lut_addr_sel
);
    localparam int FRAME_W = ADDR_W + 1 + DLY_W + CTL_W;

    logic [FRAME_W-1:0] frame;
    logic               commit;
    logic [ADDR_W-1:0]  f_addr;
    logic               f_wr;
    logic [DLY_W-1:0]   f_dly;
    logic [CTL_W-1:0]   f_ctl;

    assign f_addr = frame[FRAME_W-1 -: ADDR_W];
    assign f_wr   = frame[DLY_W + CTL_W];
    assign f_dly  = frame[CTL_W +: DLY_W];
    assign f_ctl  = frame[CTL_W-1:0];

    bfcfg_ddr_rx #(.FRAME_W(FRAME_W)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .sdi      (cfg_sdi),
        .sle      (cfg_sle),
        .tx_start (tx_start),
        .frame    (frame),
        .commit   (commit)
    );

    bfcfg_fsm #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DLY_W  (DLY_W),
        .CTL_W  (CTL_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .f_addr   (f_addr),
        .f_wr     (f_wr),
        .f_dly    (f_dly),
        .f_ctl    (f_ctl),
        .dly_flat (ch_delay),
        .ctl_q    (ctl_word),
        .sdo      (cfg_sdo)
    );

    bfcfg_ctl_decode #(
        .NUM_CH (NUM_CH),
        .CTL_W  (CTL_W)
    ) u_dec (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_word),
        .ch_en (ch_enable),
        .plen  (pulse_len),
        .fdiv  (freq_div),
        .dop   (doppler_mode),
        .lut_d (lut_data_sel),
        .lut_a (lut_addr_sel)
    );
endmodule

// File: tb/bf_serial_cfg_bench.sv
`timescale 1ns/1ps
module bf_serial_cfg_bench;
    localparam int NCH = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_sdi, cfg_sle, tx_start;
    logic         cfg_sdo;
    logic [399:0] ch_delay;
    logic [18:0]  ctl_word;
    logic [15:0]  ch_enable;
    logic [2:0]   pulse_len;
    logic [6:0]   freq_div;
    logic         doppler_mode, lut_data_sel, lut_addr_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [24:0] exp_dly [NCH];
    logic [18:0] exp_ctl;

    always #2.5 clk = ~clk;

    bf_serial_cfg u_bf_serial_cfg (
        .clk(clk), .rst(rst), .cfg_sdi(cfg_sdi), .cfg_sle(cfg_sle),
        .tx_start(tx_start), .cfg_sdo(cfg_sdo), .ch_delay(ch_delay),
        .ctl_word(ctl_word), .ch_enable(ch_enable), .pulse_len(pulse_len),
        .freq_div(freq_div), .doppler_mode(doppler_mode),
        .lut_data_sel(lut_data_sel), .lut_addr_sel(lut_addr_sel)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [24:0] dval(input int i, input int salt);
        logic [31:0] v;
        v = (32'(i) + 32'd1) * 32'h0013_579B ^ (32'h00AA_5501 + 32'(salt) * 32'h0101_0303);
        return v[24:0];
    endfunction

    // send npairs bit pairs of a 50-bit frame, MSB first, then drop latch enable
    task automatic send_frame(input logic [4:0] addr, input logic wr, input logic [24:0] dly,
                              input logic [18:0] ctl, input int npairs);
        logic [49:0] f;
        f = {addr, wr, dly, ctl};
        for (int i = 0; i < npairs; i++) begin
            @(posedge clk); #1;
            cfg_sle = 1'b1;
            cfg_sdi = (2*i < 50) ? f[49-2*i] : 1'b0;
            #2.5;
            cfg_sdi = (2*i + 1 < 50) ? f[48-2*i] : 1'b0;
        end
        @(posedge clk); #1;
        cfg_sle = 1'b0;
        cfg_sdi = 1'b0;
    endtask

    task automatic settle();
        repeat (30) @(posedge clk);
        #2;
    endtask

    task automatic read_bits(input int n, output logic [24:0] v);
        v = '0;
        repeat (3) @(posedge clk);
        for (int k = 0; k < n; k++) begin
            #2;
            v = {v[23:0], cfg_sdo};
            @(posedge clk);
        end
    endtask

    task automatic check_all_regs(input string req);
        for (int i = 0; i < NCH; i++)
            check(ch_delay[i*25 +: 25] == exp_dly[i], req, 64'(ch_delay[i*25 +: 25]), 64'(exp_dly[i]));
        check(ctl_word == exp_ctl, req, 64'(ctl_word), 64'(exp_ctl));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [24:0] rv;
        logic [18:0] c;
        rst = 1'b1; cfg_sdi = 1'b0; cfg_sle = 1'b0; tx_start = 1'b0;
        for (int i = 0; i < NCH; i++) exp_dly[i] = '0;
        exp_ctl = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        // R1: reset state
        check(ch_delay == '0, "R1", 64'(ch_delay[63:0]), 64'h0);
        check(ctl_word == '0, "R1", 64'(ctl_word), 64'h0);
        check(cfg_sdo == 1'b0, "R1", 64'(cfg_sdo), 64'h0);
        check(ch_enable == 16'h0003, "R9 reset", 64'(ch_enable), 64'h3);

        // R2/R5: write every channel, then compare the whole bus
        for (int i = 0; i < NCH; i++) begin
            exp_dly[i] = dval(i, 0);
            send_frame(5'(i + 1), 1'b1, exp_dly[i], 19'h5A5A5, 25);
            settle();
        end
        check_all_regs("R5 write sweep");

        // R4: back-to-back frames with minimal gap are both served
        exp_dly[2] = dval(2, 7);
        exp_dly[9] = dval(9, 7);
        send_frame(5'd3, 1'b1, exp_dly[2], 19'h0, 25);
        send_frame(5'd10, 1'b1, exp_dly[9], 19'h0, 25);
        settle();
        check_all_regs("R4 back-to-back");

        // R7: read each channel and check exact first-bit timing
        for (int i = 0; i < NCH; i++) begin
            send_frame(5'(i + 1), 1'b0, 25'h1FFFFFF, 19'h7FFFF, 25);
            read_bits(25, rv);
            check(rv == exp_dly[i], "R7 channel read", 64'(rv), 64'(exp_dly[i]));
        end
        settle();
        check_all_regs("R7 read leaves registers");

        // R6/R9/R10: sweep all active-channel counts with mixed fields
        for (int n = 0; n < 8; n++) begin
            c = {1'(n & 1), 3'(n), 3'b111, 1'(n >> 1), 1'(n >> 2), 7'(n * 19 + 5), 3'(7 - n)};
            exp_ctl = c & ~19'h07000;
            send_frame(5'd17, 1'b1, 25'h1ABCDEF, c, 25);
            settle();
            check_all_regs("R6 control write");
            check(ch_enable == 16'((32'h1 << (2 * (n + 1))) - 1), "R9 active count",
                  64'(ch_enable), 64'((32'h1 << (2 * (n + 1))) - 1));
            check(pulse_len == exp_ctl[2:0], "R10 pattern length", 64'(pulse_len), 64'(exp_ctl[2:0]));
            check(freq_div == exp_ctl[9:3], "R10 divider", 64'(freq_div), 64'(exp_ctl[9:3]));
            check(doppler_mode == exp_ctl[10], "R10 doppler", 64'(doppler_mode), 64'(exp_ctl[10]));
            check(lut_data_sel == exp_ctl[11], "R10 lut data", 64'(lut_data_sel), 64'(exp_ctl[11]));
            check(lut_addr_sel == exp_ctl[18], "R10 lut addr", 64'(lut_addr_sel), 64'(exp_ctl[18]));
            // R7: control read-back, reserved bits zero
            send_frame(5'd17, 1'b0, 25'h0, 19'h0, 25);
            read_bits(19, rv);
            check(rv[18:0] == exp_ctl, "R7 control read", 64'(rv[18:0]), 64'(exp_ctl));
        end

        // R8: out-of-range addresses, writes and reads
        for (int a = 0; a < 32; a++) begin
            if (a >= 1 && a <= 17) continue;
            send_frame(5'(a), 1'b1, 25'h0F0F0F0, 19'h3C3C3, 25);
            settle();
            check_all_regs("R8 ignored write");
            send_frame(5'(a), 1'b0, 25'h0, 19'h0, 25);
            read_bits(25, rv);
            check(rv == '0, "R8 ignored read", 64'(rv), 64'h0);
        end

        // R11: transmit start high blocks commit
        tx_start = 1'b1;
        send_frame(5'd4, 1'b1, 25'h0123456, 19'h0, 25);
        send_frame(5'd17, 1'b1, 25'h0, 19'h7FFFF, 25);
        settle();
        tx_start = 1'b0;
        settle();
        check_all_regs("R11 tx_start blocks");

        // R3: short and long frames dropped
        send_frame(5'd5, 1'b1, 25'h1555555, 19'h0, 24);
        settle();
        check_all_regs("R3 short frame");
        send_frame(5'd6, 1'b1, 25'h0AAAAAA, 19'h0, 26);
        settle();
        check_all_regs("R3 long frame");
        send_frame(5'd17, 1'b1, 25'h0, 19'h7FFFF, 24);
        settle();
        check_all_regs("R3 short control frame");

        // R2: a final valid frame after the rejects still lands (pair order intact)
        exp_dly[15] = 25'h1000001;
        send_frame(5'd16, 1'b1, exp_dly[15], 19'h0, 25);
        settle();
        check_all_regs("R2 edge pair order");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule